// File: doc/BRIEF.md
# Program-Loop Watchdog with Selectable Timeout

This block watches for software that has stopped making progress. It runs from the main system clock. Software configures it with three settings: an enable, a choice of response, and a 3-bit timeout code. Software then writes the run bit to start it. From then on, software must write the run bit again before the chosen interval runs out. If that write does not come in time, the block emits a one-cycle request. The request is either a system reset or a non-maskable interrupt, depending on the response setting.

The counter has two parts. The lower part is a free-running 2^PRE_BITS prescaler that a restart never touches. The upper part is a stage whose terminal count comes from the timeout code. Because the prescaler is never cleared, the real interval can fall short of the nominal one by up to one prescaler period. Counting is frozen while the CPU is stopped or running from the subsystem clock. It continues while the CPU is halted.

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `wdt_guard`

## Requirements
- R1: After reset, both request outputs are 0, the watchdog is not running, and the configuration is enable=0, response=reset, code=0.
- R2: A configuration write (cfg_we) is accepted only while the watchdog has never been started since reset. Once it has started, configuration writes are ignored, and the timeout length and response keep their earlier values.
- R3: A run write (run_we with run_val=1) starts the watchdog only when the enable setting is 1. With enable=0, no request is ever produced.
- R4: Every accepted run write clears the upper counter stage and restarts the interval. Writes spaced closer than the interval prevent any request.
- R5: Timeout code c (0 to 6) gives a nominal interval N = 2^(BASE_EXP+c) clocks, and code 7 gives N = 2^(BASE_EXP+8). The request pulse appears k clocks after the run-write edge, with N-2^PRE_BITS < k <= N (active clocks only).
- R6: With cfg_nmi_sel=1 the request appears on nmi_req, otherwise on rst_req. The two outputs are never high together.
- R7: Each request is high for exactly one cycle. After it, no further request occurs until the next accepted run write.
- R8: cpu_halt has no effect: the interval with halt held high is the same as without it.
- R9: While cpu_stop is 1, the prescaler and the upper stage both hold and no request is issued. The frozen clocks add exactly to the interval.
- R10: While cpu_on_subclk is 1, counting holds exactly as in R9.
- R11: A run write with run_val=0 is ignored: it neither stops nor restarts the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdt_en | input | 1 | Watchdog enable value written with cfg_we |
| cfg_nmi_sel | input | 1 | Response on timeout: 1 = NMI, 0 = system reset |
| cfg_sel | input | 3 | Timeout code written with cfg_we |
| run_we | input | 1 | Run bit write strobe |
| run_val | input | 1 | Value written to the run bit |
| cpu_halt | input | 1 | CPU is in HALT mode |
| cpu_stop | input | 1 | CPU is in STOP mode |
| cpu_on_subclk | input | 1 | CPU is clocked from the subsystem clock |
| rst_req | output | 1 | One-cycle system reset request |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request |

## Verification
The main timeout path is tried with all eight codes, with alternating response settings. Each run starts at whatever prescaler phase the sweep leaves behind, so the measured interval checks the stated window rather than a single exact value. Regular kicks spaced inside the interval must hold off every request, which shows that restarts are not being missed. Freezing windows on STOP and on the subsystem-clock flag, set against a HALT level held for a full interval, show which conditions pause the count. Zero-valued run writes and configuration writes issued after start must leave the interval and the response unchanged.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int SEL_W     = 3;
  localparam int NUM_CODES = 1 << SEL_W;
  localparam int TOP_EXTRA = 8;  // extra stages used by the longest code

  typedef enum logic {
    RESP_RESET = 1'b0,
    RESP_NMI   = 1'b1
  } resp_e;

  typedef struct packed {
    logic             en;
    resp_e            resp;
    logic [SEL_W-1:0] sel;
  } wdt_cfg_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRE_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic tick
);
  logic [PRE_BITS-1:0] cnt_q;

  // never cleared by a restart: it only counts while clocks are live
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (adv) cnt_q <= cnt_q + 1'b1;
  end

  assign tick = adv & (&cnt_q);
endmodule

// File: rtl/wdt_stage.sv
module wdt_stage
  import wdt_pkg::*;
#(
  parameter int SPAN0 = 4,
  parameter int UP_W  = SPAN0 + TOP_EXTRA
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  input  logic [SEL_W-1:0] sel,
  output logic             expire
);
  logic [UP_W-1:0] cnt_q;
  logic [UP_W-1:0] lim [NUM_CODES];

  for (genvar c = 0; c < NUM_CODES; c++) begin : g_lim
    localparam int EXP = SPAN0 + ((c == NUM_CODES-1) ? TOP_EXTRA : c);
    assign lim[c] = {UP_W{1'b1}} >> (UP_W - EXP);
  end

  assign expire = step & (cnt_q == lim[sel]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (restart)     cnt_q <= '0;
    else if (expire)      cnt_q <= '0;
    else if (step)        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cfg_we,
  input  wdt_cfg_t cfg_new,
  input  logic     run_we,
  input  logic     run_val,
  input  logic     expire,
  output wdt_cfg_t cfg_q,
  output logic     restart,
  output logic     armed_q,
  output logic     rst_req,
  output logic     nmi_req
);
  logic started_q;

  assign restart = run_we & run_val & cfg_q.en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '{en: 1'b0, resp: RESP_RESET, sel: '0};
      started_q <= 1'b0;
      armed_q   <= 1'b0;
      rst_req   <= 1'b0;
      nmi_req   <= 1'b0;
    end else begin
      if (cfg_we && !started_q) cfg_q <= cfg_new;
      if (restart) begin
        started_q <= 1'b1;
        armed_q   <= 1'b1;
      end else if (expire) begin
        armed_q   <= 1'b0;
      end
      rst_req <= expire & (cfg_q.resp == RESP_RESET);
      nmi_req <= expire & (cfg_q.resp == RESP_NMI);
    end
  end
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int PRE_BITS = 8,
  parameter int BASE_EXP = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_wdt_en,
  input  logic             cfg_nmi_sel,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic             run_we,
  input  logic             run_val,
  input  logic             cpu_halt,
  input  logic             cpu_stop,
  input  logic             cpu_on_subclk,
  output logic             rst_req,
  output logic             nmi_req
);
  localparam int SPAN0 = BASE_EXP - PRE_BITS;
  localparam int UP_W  = SPAN0 + TOP_EXTRA;

  wdt_cfg_t cfg_new, cfg_q;
  logic     clk_live, pre_tick, restart, armed, step, expire;
  logic     unused_halt;

  // HALT keeps the main clock running, so it does not gate the count
  assign unused_halt = cpu_halt;
  assign clk_live    = ~cpu_stop & ~cpu_on_subclk;
  assign cfg_new     = '{en: cfg_wdt_en, resp: resp_e'(cfg_nmi_sel), sel: cfg_sel};
  assign step        = pre_tick & armed & ~restart;

  wdt_prescaler #(.PRE_BITS(PRE_BITS)) u_pre (
    .clk(clk), .rst_n(rst_n), .adv(clk_live), .tick(pre_tick)
  );

  wdt_stage #(.SPAN0(SPAN0), .UP_W(UP_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .restart(restart), .step(step),
    .sel(cfg_q.sel), .expire(expire)
  );

  wdt_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_new(cfg_new),
    .run_we(run_we), .run_val(run_val), .expire(expire),
    .cfg_q(cfg_q), .restart(restart), .armed_q(armed),
    .rst_req(rst_req), .nmi_req(nmi_req)
  );
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic cpu_stop,
  input logic cpu_on_subclk,
  input logic rst_req,
  input logic nmi_req
);
  // R6
  resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && nmi_req));
  // R7
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R7
  nmi_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> !nmi_req);
  // R9
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stop |=> !(rst_req || nmi_req));
  // R10
  subclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_on_subclk |=> !(rst_req || nmi_req));
endmodule

bind wdt_guard wdt_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_stop(cpu_stop),
  .cpu_on_subclk(cpu_on_subclk), .rst_req(rst_req), .nmi_req(nmi_req)
);

// File: tb/wdt_guard_tb_top.sv
module wdt_guard_tb_top;
  localparam int P    = 2;
  localparam int BASE = 4;
  localparam int PRE  = 1 << P;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_wdt_en = 0, cfg_nmi_sel = 0;
  logic [2:0] cfg_sel = 0;
  logic run_we = 0, run_val = 0, cpu_halt = 0, cpu_stop = 0, cpu_on_subclk = 0;
  logic rst_req, nmi_req;

  int checks = 0, failures = 0;
  bit comparing = 0, done = 0;

  always #5 clk = ~clk;

  wdt_guard #(.PRE_BITS(P), .BASE_EXP(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdt_en(cfg_wdt_en),
    .cfg_nmi_sel(cfg_nmi_sel), .cfg_sel(cfg_sel), .run_we(run_we),
    .run_val(run_val), .cpu_halt(cpu_halt), .cpu_stop(cpu_stop),
    .cpu_on_subclk(cpu_on_subclk), .rst_req(rst_req), .nmi_req(nmi_req)
  );

  function automatic int ticks_for(int code);
    return (code == 7) ? (1 << (BASE - P + 8)) : (1 << (BASE - P + code));
  endfunction

  // behavioural reference
  int m_pre = 0, m_up = 0, m_sel = 0;
  bit m_armed = 0, m_started = 0, m_en = 0, m_nmi = 0;
  bit exp_rst = 0, exp_nmi = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_up = 0; m_sel = 0; m_armed = 0; m_started = 0;
      m_en = 0; m_nmi = 0; exp_rst = 0; exp_nmi = 0;
    end else begin
      bit live, tick, was_started, kick;
      live = !cpu_stop && !cpu_on_subclk;
      tick = live && (m_pre == PRE - 1);
      was_started = m_started;
      kick = run_we && run_val && m_en;
      exp_rst = 0; exp_nmi = 0;
      if (live) m_pre = (m_pre + 1) % PRE;
      if (kick) begin
        m_up = 0; m_armed = 1; m_started = 1;
      end else if (m_armed && tick) begin
        if (m_up == ticks_for(m_sel) - 1) begin
          if (m_nmi) exp_nmi = 1; else exp_rst = 1;
          m_armed = 0; m_up = 0;
        end else m_up++;
      end
      if (cfg_we && !was_started) begin
        m_en = cfg_wdt_en; m_nmi = cfg_nmi_sel; m_sel = cfg_sel;
      end
    end
  end

  always @(negedge clk) if (comparing && rst_n && !done) begin
    checks++;
    if (rst_req !== exp_rst || nmi_req !== exp_nmi) begin
      failures++;
      $display("FAIL R5 cycle compare rst_req=%0b exp=%0b nmi_req=%0b exp=%0b",
               rst_req, exp_rst, nmi_req, exp_nmi);
    end
  end

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1; comparing = 1;
  endtask

  task automatic cfg_write(bit en, bit nmi, int sel);
    @(negedge clk);
    cfg_we = 1; cfg_wdt_en = en; cfg_nmi_sel = nmi; cfg_sel = 3'(sel);
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic quiet(int n, string tag);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rst_req || nmi_req) hits++;
    end
    check(hits == 0, tag, hits, 0);
  endtask

  // fkind: 0 none, 1 halt held, 2 stop window, 3 subclk window
  // xkind: 0 none, 1 run write of 0 at xat, 2 cfg write (1,1,7) at xat
  task automatic run_case(int code, bit want_nmi, int fkind, int fat, int flen,
                          int xkind, int xat, string tag);
    int d = 0, k, n_nom, lost;
    n_nom = ticks_for(code) * PRE;
    lost = (fkind >= 2) ? flen : 0;
    @(negedge clk);
    run_we = 1; run_val = 1;
    if (fkind == 1) cpu_halt = 1;
    forever begin
      @(negedge clk); d++;
      if (d == 1) begin run_we = 0; run_val = 0; end
      if (cfg_we) cfg_we = 0;
      if (xkind == 1 && d == xat) begin run_we = 1; run_val = 0; end
      if (xkind == 1 && d == xat + 1) run_we = 0;
      if (xkind == 2 && d == xat) begin
        cfg_we = 1; cfg_wdt_en = 1; cfg_nmi_sel = 1; cfg_sel = 3'd7;
      end
      if (fkind == 2 && d == fat) cpu_stop = 1;
      if (fkind == 3 && d == fat) cpu_on_subclk = 1;
      if (fkind >= 2 && d == fat + flen) begin cpu_stop = 0; cpu_on_subclk = 0; end
      if (rst_req || nmi_req) break;
      if (d > 2 * n_nom + lost + 50) break;
    end
    cpu_halt = 0;
    k = d - 1 - lost;
    check(k > n_nom - PRE && k <= n_nom, {tag, " interval"}, k, n_nom);
    check(nmi_req == want_nmi && rst_req == !want_nmi, "R6 response pin",
          int'(nmi_req), int'(want_nmi));
    @(negedge clk);
    check(!rst_req && !nmi_req, "R7 single cycle", int'(rst_req | nmi_req), 0);
    quiet(60, "R7 stays idle after request");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; failures++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1
    check(!rst_req && !nmi_req, "R1 outputs after reset", int'(rst_req | nmi_req), 0);
    quiet(40, "R1 idle without start");

    // R3: disabled watchdog ignores run write
    cfg_write(0, 0, 0);
    @(negedge clk); run_we = 1; run_val = 1;
    @(negedge clk); run_we = 0; run_val = 0;
    quiet(200, "R3 disabled never requests");

    // R5/R6 sweep over every code
    for (int c = 0; c < 8; c++) begin
      do_reset();
      repeat (c) @(negedge clk);
      cfg_write(1, c[0], c);
      run_case(c, c[0], 0, 0, 0, 0, 0, "R5 code sweep");
    end

    // R4: regular kicks hold off the request
    do_reset();
    cfg_write(1, 0, 2);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); run_we = 1; run_val = 1;
      @(negedge clk); run_we = 0; run_val = 0;
      repeat (40) begin
        @(negedge clk);
        if (rst_req || nmi_req) check(0, "R4 kick held off", 1, 0);
      end
    end
    check(1, "R4 kicks done", 0, 0);
    // R11: zero write neither stops nor restarts
    run_case(2, 0, 0, 0, 0, 1, 20, "R11 zero write ignored");

    // R2: configuration locked after start
    do_reset();
    cfg_write(1, 0, 1);
    run_case(1, 0, 0, 0, 0, 2, 5, "R2 config locked");

    // R8: halt held throughout
    do_reset();
    cfg_write(1, 1, 1);
    run_case(1, 1, 1, 0, 0, 0, 0, "R8 halt ignored");

    // R9: stop window
    do_reset();
    cfg_write(1, 0, 1);
    run_case(1, 0, 2, 10, 100, 0, 0, "R9 stop freezes");

    // R10: subsystem clock window
    do_reset();
    cfg_write(1, 1, 2);
    run_case(2, 1, 3, 7, 90, 0, 0, "R10 subclk freezes");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule